// File: doc/BRIEF.md
# SPI Register and Frame Buffer Port

This block is an SPI slave that lets a host controller reach two storage areas inside a radio front end: a 64-entry register file of 8-bit registers and a 128-byte buffer holding the payload of one packet. The SPI bus runs in mode 0 with the most significant bit first. The pins are oversampled by the system clock through a synchronizer, so the SPI clock must be several system clocks per half period.

Every transaction opens with the select line going low. The first byte the host shifts in is a command. While it is being shifted in, the slave returns the current physical-layer status byte. Register commands move a single data byte. Frame commands move a length byte and then the payload. A frame read also returns a trailing link-quality byte after the last payload byte. The status and link-quality values come in on plain input ports. Raising the select line ends or aborts the transaction at any point.

Top module: `spi_frame_port`

## Requirements
- R1: SPI mode 0, MSB first. Command bits [7:6] pick the access: 2'b11 is register write, 2'b10 is register read, 2'b01 is frame access and 2'b00 is no operation. A no-operation transaction returns 0x00 on every byte after the command.
- R2: During the command byte, MISO shifts out the value of the status input captured when the select line fell, MSB first.
- R3: A register write stores the byte after the command into the register addressed by command bits [5:0]. Any later bytes in the same transaction change no register.
- R4: A register read returns the addressed register in the byte after the command, and 0x00 in every later byte.
- R5: Raising the select line discards any partly shifted byte and returns the slave to waiting for a command, so a write cut off before its eighth data bit stores nothing.
- R6: A frame write (command 2'b01 with bit 5 = 1) stores the byte after the command as the frame length, and the following bytes into buffer locations 0, 1, 2 and on. Payload bytes past location 127 are ignored.
- R7: A frame read (command 2'b01 with bit 5 = 0) returns the stored length in the byte after the command, then buffer locations 0 onward for min(length, 128) bytes, then one link-quality byte, then 0x00 for any further byte.
- R8: Command bits [4:0] of a frame command have no effect.
- R9: MISO carries 0x00 in the data bytes of register writes and frame writes.
- R10: After reset every register and the stored frame length read as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck_i | input | 1 | SPI serial clock, idle low |
| spi_cs_n_i | input | 1 | SPI select, active low |
| spi_mosi_i | input | 1 | Serial data from the host |
| spi_miso_o | output | 1 | Serial data to the host, low while deselected |
| phy_status_i | input | 8 | Status byte returned during the command byte |
| link_qual_i | input | 8 | Link-quality byte appended to frame reads |

## Verification
The bench writes a frame of 131 payload bytes and then reads it back past its end. A slave that wrapped the buffer index would overwrite locations 0 to 2, and one that did not clamp the length would send stale bytes where the link-quality byte belongs. A write cut off after four data bits is then read back. A design that committed partial bytes, or did not clear its bit counter on deselect, would return a changed register. Register writes with extra trailing bytes are read back at the next address, which catches a design that auto-increments. Frame commands with random reserved bits, and no-operation commands, are checked for any stray effect.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

    typedef enum logic [2:0] {
        K_NONE   = 3'd0,
        K_REG_RD = 3'd1,
        K_REG_WR = 3'd2,
        K_FB_RD  = 3'd3,
        K_FB_WR  = 3'd4
    } kind_e;

    localparam logic [1:0] OP_REG_WR = 2'b11;
    localparam logic [1:0] OP_REG_RD = 2'b10;
    localparam logic [1:0] OP_FRAME  = 2'b01;
    localparam int         FB_DIR_BIT = 5;

endpackage

// File: rtl/sfp_sync.sv
module sfp_sync #(
    parameter int               WIDTH  = 3,
    parameter int               STAGES = 2,
    parameter logic [WIDTH-1:0] INIT   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= INIT;
                    else        stage_q[g] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= INIT;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/sfp_mem.sv
module sfp_mem #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [WIDTH-1:0]         wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [WIDTH-1:0]         rdata
);

    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/sfp_seq.sv
module sfp_seq
    import sfp_pkg::*;
#(
    parameter int REG_DEPTH = 64,
    parameter int FB_DEPTH  = 128
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cs_s,
    input  logic                         sck_s,
    input  logic                         mosi_s,
    input  logic [7:0]                   status_i,
    input  logic [7:0]                   lqi_i,
    output logic                         miso_o,
    output logic                         reg_we,
    output logic [$clog2(REG_DEPTH)-1:0] reg_waddr,
    output logic [7:0]                   reg_wdata,
    output logic [$clog2(REG_DEPTH)-1:0] reg_raddr,
    input  logic [7:0]                   reg_rdata,
    output logic                         fb_we,
    output logic [$clog2(FB_DEPTH)-1:0]  fb_waddr,
    output logic [7:0]                   fb_wdata,
    output logic [$clog2(FB_DEPTH)-1:0]  fb_raddr,
    input  logic [7:0]                   fb_rdata
);

    localparam int RA_W   = $clog2(REG_DEPTH);
    localparam int FA_W   = $clog2(FB_DEPTH);
    localparam int SLOT_W = $clog2(FB_DEPTH + 4) + 1;
    localparam logic [SLOT_W-1:0] SLOT_MAX = '1;
    localparam logic [SLOT_W-1:0] FB_LIM   = SLOT_W'(FB_DEPTH);

    typedef struct packed {
        logic              cs_prev;
        logic              sck_prev;
        logic [2:0]        bit_cnt;
        logic [6:0]        rx;
        logic [7:0]        tx;
        logic [7:0]        tx_nxt;
        logic [SLOT_W-1:0] slot;
        kind_e             kind;
        logic [RA_W-1:0]   addr;
        logic [7:0]        len;
    } st_t;

    st_t st_d, st_q;

    logic [7:0] cur_byte;
    logic       sck_rise;
    logic       sck_fall;

    assign cur_byte = {st_q.rx, mosi_s};
    assign sck_rise = !cs_s && sck_s && !st_q.sck_prev;
    assign sck_fall = !cs_s && !sck_s && st_q.sck_prev;

    always_comb begin
        logic [SLOT_W-1:0] pay;
        logic [SLOT_W-1:0] pidx;
        logic [SLOT_W-1:0] widx;

        st_d      = st_q;
        reg_we    = 1'b0;
        reg_waddr = st_q.addr;
        reg_wdata = cur_byte;
        reg_raddr = st_q.addr;
        fb_we     = 1'b0;
        fb_waddr  = '0;
        fb_wdata  = cur_byte;
        fb_raddr  = '0;

        pay  = (SLOT_W'(st_q.len) > FB_LIM) ? FB_LIM : SLOT_W'(st_q.len);
        pidx = st_q.slot - SLOT_W'(1);
        widx = st_q.slot - SLOT_W'(2);

        st_d.cs_prev  = cs_s;
        st_d.sck_prev = sck_s;

        if (cs_s) begin
            st_d.bit_cnt = '0;
            st_d.slot    = '0;
            st_d.kind    = K_NONE;
            st_d.rx      = '0;
            st_d.tx      = '0;
            st_d.tx_nxt  = '0;
        end else if (st_q.cs_prev) begin
            st_d.tx      = status_i;
            st_d.bit_cnt = '0;
            st_d.slot    = '0;
        end else if (sck_rise) begin
            st_d.rx      = cur_byte[6:0];
            st_d.bit_cnt = st_q.bit_cnt + 3'd1;
            if (st_q.bit_cnt == 3'd7) begin
                if (st_q.slot != SLOT_MAX) st_d.slot = st_q.slot + SLOT_W'(1);
                st_d.tx_nxt = '0;
                if (st_q.slot == '0) begin
                    unique case (cur_byte[7:6])
                        OP_REG_WR: st_d.kind = K_REG_WR;
                        OP_REG_RD: st_d.kind = K_REG_RD;
                        OP_FRAME:  st_d.kind = cur_byte[FB_DIR_BIT] ? K_FB_WR : K_FB_RD;
                        default:   st_d.kind = K_NONE;
                    endcase
                    st_d.addr = cur_byte[RA_W-1:0];
                    reg_raddr = cur_byte[RA_W-1:0];
                    if (st_d.kind == K_REG_RD)     st_d.tx_nxt = reg_rdata;
                    else if (st_d.kind == K_FB_RD) st_d.tx_nxt = st_q.len;
                end else begin
                    unique case (st_q.kind)
                        K_REG_WR: begin
                            if (st_q.slot == SLOT_W'(1)) reg_we = 1'b1;
                        end
                        K_FB_WR: begin
                            if (st_q.slot == SLOT_W'(1)) begin
                                st_d.len = cur_byte;
                            end else if (widx < FB_LIM) begin
                                fb_we    = 1'b1;
                                fb_waddr = widx[FA_W-1:0];
                            end
                        end
                        K_FB_RD: begin
                            if (pidx < pay) begin
                                fb_raddr    = pidx[FA_W-1:0];
                                st_d.tx_nxt = fb_rdata;
                            end else if (pidx == pay) begin
                                st_d.tx_nxt = lqi_i;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end else if (sck_fall) begin
            if (st_q.bit_cnt == 3'd0) st_d.tx = st_q.tx_nxt;
            else                      st_d.tx = {st_q.tx[6:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.cs_prev <= 1'b1;
            st_q.kind    <= K_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign miso_o = !cs_s && st_q.tx[7];

    // R5: deselect clears the byte position and the decoded command
    p_idle_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (st_q.slot == '0 && st_q.bit_cnt == 3'd0 && st_q.kind == K_NONE));

    // R2: the status byte is captured on the select edge
    p_status_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cs_prev && !cs_s) |=> (st_q.tx == $past(status_i)));

    // R3: a register store happens only for the first data byte of a write
    p_reg_write_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (st_q.kind == K_REG_WR && st_q.slot == SLOT_W'(1) && sck_rise));

    // R6: buffer stores only for payload bytes of a frame write
    p_fb_write_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we |-> (st_q.kind == K_FB_WR && st_q.slot >= SLOT_W'(2)));

    // R3: at most one storage area is written per cycle
    p_single_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && fb_we));

    // R1: the byte position only ever advances by one while selected
    p_slot_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_s && !st_q.cs_prev && st_q.slot != SLOT_MAX) |=>
            (st_q.slot == $past(st_q.slot) || st_q.slot == $past(st_q.slot) + SLOT_W'(1)));

endmodule

// File: rtl/spi_frame_port.sv
module spi_frame_port #(
    parameter int REG_DEPTH   = 64,
    parameter int FB_DEPTH    = 128,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sck_i,
    input  logic       spi_cs_n_i,
    input  logic       spi_mosi_i,
    output logic       spi_miso_o,
    input  logic [7:0] phy_status_i,
    input  logic [7:0] link_qual_i
);

    localparam int RA_W = $clog2(REG_DEPTH);
    localparam int FA_W = $clog2(FB_DEPTH);

    logic [2:0] pins_s;
    logic [RA_W-1:0] reg_waddr, reg_raddr;
    logic [FA_W-1:0] fb_waddr, fb_raddr;
    logic [7:0]      reg_wdata, reg_rdata, fb_wdata, fb_rdata;
    logic            reg_we, fb_we;

    sfp_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .INIT   (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({spi_cs_n_i, spi_sck_i, spi_mosi_i}),
        .dout  (pins_s)
    );

    sfp_seq #(
        .REG_DEPTH (REG_DEPTH),
        .FB_DEPTH  (FB_DEPTH)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s      (pins_s[2]),
        .sck_s     (pins_s[1]),
        .mosi_s    (pins_s[0]),
        .status_i  (phy_status_i),
        .lqi_i     (link_qual_i),
        .miso_o    (spi_miso_o),
        .reg_we    (reg_we),
        .reg_waddr (reg_waddr),
        .reg_wdata (reg_wdata),
        .reg_raddr (reg_raddr),
        .reg_rdata (reg_rdata),
        .fb_we     (fb_we),
        .fb_waddr  (fb_waddr),
        .fb_wdata  (fb_wdata),
        .fb_raddr  (fb_raddr),
        .fb_rdata  (fb_rdata)
    );

    sfp_mem #(.DEPTH(REG_DEPTH), .WIDTH(8)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .waddr (reg_waddr),
        .wdata (reg_wdata),
        .raddr (reg_raddr),
        .rdata (reg_rdata)
    );

    sfp_mem #(.DEPTH(FB_DEPTH), .WIDTH(8)) u_fbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (fb_we),
        .waddr (fb_waddr),
        .wdata (fb_wdata),
        .raddr (fb_raddr),
        .rdata (fb_rdata)
    );

endmodule

// File: tb/tb_spi_frame_port.sv
module tb_spi_frame_port;

    localparam int HP = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic       mosi = 1'b0;
    logic       miso;
    logic [7:0] status = 8'h00;
    logic [7:0] lqi = 8'h00;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] reg_m [64];
    logic [7:0] buf_m [128];
    logic [7:0] len_m;

    always #2 clk = ~clk;

    spi_frame_port dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .spi_sck_i    (sck),
        .spi_cs_n_i   (cs_n),
        .spi_mosi_i   (mosi),
        .spi_miso_o   (miso),
        .phy_status_i (status),
        .link_qual_i  (lqi)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer_bits(input logic [7:0] b, input int n, output logic [7:0] r);
        r = '0;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = b[i];
            repeat (HP) @(negedge clk);
            r[i] = miso;
            sck = 1'b1;
            repeat (HP) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] b, output logic [7:0] r);
        xfer_bits(b, 8, r);
    endtask

    task automatic open_tx();
        status = 8'($urandom);
        lqi    = 8'($urandom);
        cs_n   = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic close_tx();
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_frame(input int s);
        int pay;
        int p;
        pay = (len_m > 8'd128) ? 128 : int'(len_m);
        if (s == 1) return len_m;
        p = s - 2;
        if (p < pay) return buf_m[p];
        if (p == pay) return lqi;
        return 8'h00;
    endfunction

    task automatic reg_wr(input logic [5:0] a, input logic [7:0] v, input int extra);
        logic [7:0] r;
        open_tx();
        xfer({2'b11, a}, r);
        chk("R2 status during reg write command", r, status);
        xfer(v, r);
        chk("R9 reg write data slot", r, 8'h00);
        for (int k = 0; k < extra; k++) begin
            xfer(8'($urandom), r);
            chk("R9 reg write trailing slot", r, 8'h00);
        end
        close_tx();
        reg_m[a] = v;
    endtask

    task automatic reg_rd(input logic [5:0] a, input int extra, input string req);
        logic [7:0] r;
        open_tx();
        xfer({2'b10, a}, r);
        chk("R2 status during reg read command", r, status);
        xfer(8'($urandom), r);
        chk(req, r, reg_m[a]);
        for (int k = 0; k < extra; k++) begin
            xfer(8'($urandom), r);
            chk("R4 reg read trailing slot", r, 8'h00);
        end
        close_tx();
    endtask

    task automatic fb_wr(input logic [4:0] low, input logic [7:0] len, input int npay);
        logic [7:0] r;
        logic [7:0] v;
        open_tx();
        xfer({3'b011, low}, r);
        chk("R2 status during frame write command", r, status);
        xfer(len, r);
        chk("R9 frame write length slot", r, 8'h00);
        for (int k = 0; k < npay; k++) begin
            v = 8'($urandom);
            xfer(v, r);
            chk("R9 frame write payload slot", r, 8'h00);
            if (k < 128) buf_m[k] = v;
        end
        close_tx();
        len_m = len;
    endtask

    task automatic fb_rd(input logic [4:0] low, input int n, input string req);
        logic [7:0] r;
        open_tx();
        xfer({3'b010, low}, r);
        chk("R2 status during frame read command", r, status);
        for (int s = 1; s <= n; s++) begin
            xfer(8'($urandom), r);
            chk(req, r, exp_frame(s));
        end
        close_tx();
    endtask

    task automatic nop_tx(input logic [5:0] low, input int n);
        logic [7:0] r;
        open_tx();
        xfer({2'b00, low}, r);
        chk("R2 status during no-op command", r, status);
        for (int k = 0; k < n; k++) begin
            xfer(8'($urandom), r);
            chk("R1 no-op data slot", r, 8'h00);
        end
        close_tx();
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] r;
        void'($urandom(32'd1234));
        for (int i = 0; i < 64; i++)  reg_m[i] = 8'h00;
        for (int i = 0; i < 128; i++) buf_m[i] = 8'h00;
        len_m = 8'h00;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R5 miso low while deselected", {7'd0, miso}, 8'h00);

        // R10: reset contents
        reg_rd(6'd0, 1, "R10 register 0 after reset");
        reg_rd(6'd63, 0, "R10 register 63 after reset");
        fb_rd(5'd0, 4, "R10 R7 frame read after reset");

        // R1: no-operation command
        nop_tx(6'h3F, 3);

        // R3: trailing bytes do not spill into other registers
        reg_wr(6'd5, 8'hA5, 2);
        reg_rd(6'd5, 1, "R3 register 5 written");
        reg_rd(6'd6, 0, "R3 register 6 untouched by trailing bytes");

        // R5: aborted write stores nothing
        open_tx();
        xfer(8'hC7, r);
        chk("R2 status during aborted command", r, status);
        xfer_bits(8'hFF, 4, r);
        close_tx();
        reg_rd(6'd7, 0, "R5 register 7 after aborted write");
        open_tx();
        xfer_bits(8'hC9, 5, r);
        close_tx();
        reg_rd(6'd9, 0, "R5 register 9 after aborted command");

        // R6 R8: oversized frame with reserved bits set
        fb_wr(5'h1F, 8'd131, 131);
        fb_rd(5'h15, 132, "R6 R7 oversized frame read back");

        // R7: short frame over stale buffer contents
        fb_wr(5'h00, 8'd3, 2);
        fb_rd(5'h0A, 6, "R7 short frame read back");

        // Randomized mix
        for (int t = 0; t < 30; t++) begin
            int sel;
            int ln;
            sel = $urandom_range(0, 4);
            case (sel)
                0: reg_wr(6'($urandom), 8'($urandom), $urandom_range(0, 2));
                1: reg_rd(6'($urandom), $urandom_range(0, 2), "R4 random register read");
                2: begin
                    ln = $urandom_range(0, 24);
                    fb_wr(5'($urandom), 8'(ln), $urandom_range(0, 26));
                end
                3: begin
                    ln = (len_m > 8'd128) ? 128 : int'(len_m);
                    fb_rd(5'($urandom), $urandom_range(1, ln + 3), "R7 R8 random frame read");
                end
                default: nop_tx(6'($urandom), $urandom_range(0, 2));
            endcase
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule